// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates large, contiguous regions of the effective address space in one step, without any segment or page walk. It keeps four translation entries. Each entry is a pair of 32-bit words: an upper word that says which effective region it covers and in which privilege modes it is active, and a lower word that gives the real base of the region and its protection code. A lookup compares the effective address against every entry active in the current mode. The first matching entry supplies the real address and is checked against the requested access type.

Lookups arrive on a valid/ready request channel and leave on a valid/ready response channel, through one registered stage. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. A response stays on the outputs, unchanged, until `rsp_ready` is seen high. The entry write port and the privilege flag are plain control pins. A miss tells the surrounding logic to use the segment/page translation path instead. One instance is meant for instruction fetches and another for data accesses.

Top module: `bat_matcher`

## Requirements
- R1: After reset every entry is disabled, so no lookup hits until an entry has been written.
- R2: Upper-word bit 1 enables an entry in supervisor mode (`mode_problem`=0) and bit 0 enables it in problem mode (`mode_problem`=1). The privilege flag sampled with a request picks which bit applies.
- R3: The 11-bit length field in upper-word bits 12:2 extends the offset mask above bit 16: mask = {4'b0, len, 17 ones}. An enabled entry matches when every effective-address bit outside the mask equals the same bit of upper-word bits 31:17.
- R4: On a hit the real address is (ea AND mask) OR (lower-word bits 31:17 placed at bits 31:17). The low 17 bits always pass through from the effective address.
- R5: Lower-word bits 1:0 hold the protection code. Code 00 denies every access, codes 01 and 11 allow reads and fetches but deny writes, and code 10 allows every access. Access codes are 00 read, 01 write and 10 fetch; 11 is handled like a read.
- R6: When several enabled entries match, the one with the lowest index is used.
- R7: On a miss `rsp_hit`, `rsp_violation` and `rsp_real_addr` are all zero. The violation flag is raised only on a hit whose access is denied.
- R8: A write stores `wr_data` into entry `wr_idx`, lower word when `wr_lower`=1 and upper word otherwise. Only that word changes, and it is used by requests accepted after the write edge.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| mode_problem | input | 1 | 1 = problem (user) mode, 0 = supervisor |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_real_addr | output | 32 | Translated address, zero on a miss |
| rsp_violation | output | 1 | Hit with denied access |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 2 | Entry index to write |
| wr_lower | input | 1 | 1 = lower word, 0 = upper word |
| wr_data | input | 32 | Word to store |

## Verification
The hardest situation to reach is two enabled entries covering the same effective address, where only the privilege flag decides which one wins. The stimulus gives entries 0 and 3 the same region with different real bases. It then rewrites only the upper word of entry 0 to drop its problem-mode enable, and repeats the same address in both modes, so the priority order and the mode-dependent enable are both visible in the returned real address. Back-pressure is tested by holding `rsp_ready` low across several edges while the response must stay frozen and `req_ready` must stay low.

// File: rtl/bat_pkg.sv
package bat_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_e;

  // Restricted-key protection check: 00 none, 10 all, 01/11 no stores
  function automatic logic prot_allows(input logic [1:0] pp, input logic [1:0] acc);
    logic ok;
    if (pp == 2'b00)             ok = 1'b0;
    else if (acc == ACC_WRITE)   ok = (pp == 2'b10);
    else                         ok = 1'b1;
    return ok;
  endfunction
endpackage

// File: rtl/bat_entry.sv
module bat_entry #(
  parameter int AW      = 32,
  parameter int MIN_OFS = 17,
  parameter int LEN_W   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_up,
  input  logic          wr_lo,
  input  logic [AW-1:0] wr_data,
  input  logic          problem,
  input  logic [AW-1:0] ea,
  output logic          match,
  output logic [AW-1:0] ra,
  output logic [1:0]    pp
);
  localparam int PAD_W = AW - MIN_OFS - LEN_W;

  logic [AW-1:0]    upper_q, lower_q;
  logic [LEN_W-1:0] len;
  logic [AW-1:0]    ofs_mask;
  logic             enabled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      lower_q <= '0;
    end else begin
      if (wr_up) upper_q <= wr_data;
      if (wr_lo) lower_q <= wr_data;
    end
  end

  always_comb begin
    len      = upper_q[LEN_W+1:2];
    ofs_mask = {{PAD_W{1'b0}}, len, {MIN_OFS{1'b1}}};
    enabled  = problem ? upper_q[0] : upper_q[1];
    match    = enabled && ((ea & ~ofs_mask) == (upper_q & ~ofs_mask));
    ra       = (ea & ofs_mask) | {lower_q[AW-1:MIN_OFS], {MIN_OFS{1'b0}}};
    pp       = lower_q[1:0];
  end
endmodule

// File: rtl/bat_select.sv
module bat_select #(
  parameter int N  = 4,
  parameter int AW = 32
) (
  input  logic [N-1:0]       match,
  input  logic [N*AW-1:0]    ra_flat,
  input  logic [2*N-1:0]     pp_flat,
  output logic               hit,
  output logic [AW-1:0]      sel_ra,
  output logic [1:0]         sel_pp
);
  always_comb begin
    hit    = 1'b0;
    sel_ra = '0;
    sel_pp = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit    = 1'b1;
        sel_ra = ra_flat[i*AW +: AW];
        sel_pp = pp_flat[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher #(
  parameter int AW      = 32,
  parameter int ENTRIES = 4,
  parameter int MIN_OFS = 17,
  parameter int LEN_W   = 11,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_ea,
  input  logic [1:0]       req_acc,
  input  logic             mode_problem,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [AW-1:0]    rsp_real_addr,
  output logic             rsp_violation,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_lower,
  input  logic [AW-1:0]    wr_data
);
  import bat_pkg::*;

  logic [ENTRIES-1:0]    match;
  logic [ENTRIES*AW-1:0] ra_flat;
  logic [2*ENTRIES-1:0]  pp_flat;
  logic                  any_hit;
  logic [AW-1:0]         win_ra;
  logic [1:0]            win_pp;
  logic                  take;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    bat_entry #(.AW(AW), .MIN_OFS(MIN_OFS), .LEN_W(LEN_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_up   (sel && !wr_lower),
      .wr_lo   (sel && wr_lower),
      .wr_data (wr_data),
      .problem (mode_problem),
      .ea      (req_ea),
      .match   (match[g]),
      .ra      (ra_flat[g*AW +: AW]),
      .pp      (pp_flat[2*g +: 2])
    );
  end

  bat_select #(.N(ENTRIES), .AW(AW)) u_sel (
    .match   (match),
    .ra_flat (ra_flat),
    .pp_flat (pp_flat),
    .hit     (any_hit),
    .sel_ra  (win_ra),
    .sel_pp  (win_pp)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_real_addr <= '0;
      rsp_violation <= 1'b0;
    end else if (take) begin
      rsp_valid     <= 1'b1;
      rsp_hit       <= any_hit;
      rsp_real_addr <= any_hit ? win_ra : '0;
      rsp_violation <= any_hit && !prot_allows(win_pp, req_acc);
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/bat_matcher_chk.sv
module bat_matcher_chk #(
  parameter int AW      = 32,
  parameter int MIN_OFS = 17,
  parameter int IDX_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_ea,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [AW-1:0]    rsp_real_addr,
  input logic             rsp_violation,
  input logic             wr_en
);
  logic [AW-1:0] cap_ea;
  logic          any_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ea <= '0;
      any_wr <= 1'b0;
    end else begin
      if (req_valid && req_ready) cap_ea <= req_ea;
      if (wr_en) any_wr <= 1'b1;
    end
  end

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !any_wr) |-> !rsp_hit);

  assert_offset_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_real_addr[MIN_OFS-1:0] == cap_ea[MIN_OFS-1:0]));

  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_violation && rsp_real_addr == '0));

  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
      && $stable(rsp_real_addr) && $stable(rsp_violation)));
endmodule

bind bat_matcher bat_matcher_chk #(.AW(AW), .MIN_OFS(MIN_OFS), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_ea        (req_ea),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_hit       (rsp_hit),
  .rsp_real_addr (rsp_real_addr),
  .rsp_violation (rsp_violation),
  .wr_en         (wr_en)
);

// File: tb/bat_matcher_test.sv
module bat_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_acc = '0;
  logic        mode_problem = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [31:0] rsp_real_addr;
  logic        rsp_violation;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic        wr_lower = 1'b0;
  logic [31:0] wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, FE = 2'b10;

  always #10 clk = ~clk;

  bat_matcher uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [1:0] idx, input bit lower, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_lower = lower; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] ea, input logic [1:0] acc, input bit prob,
                      input bit e_hit, input logic [31:0] e_ra, input bit e_v, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_acc = acc; mode_problem = prob; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_hit == e_hit, {tag, " hit"}, 32'(rsp_hit), 32'(e_hit));
    chk(rsp_real_addr == e_ra, {tag, " ra"}, rsp_real_addr, e_ra);
    chk(rsp_violation == e_v, {tag, " viol"}, 32'(rsp_violation), 32'(e_v));
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R9 idle after reset", 32'(rsp_valid), 32'd0);
    look(32'h1000_1234, RD, 1'b0, 1'b0, 32'h0, 1'b0, "R1 empty sup");
    look(32'h0000_0000, RD, 1'b1, 1'b0, 32'h0, 1'b0, "R1 empty prob");
  endtask

  task automatic t_basic();
    wr_word(2'd0, 1'b0, 32'h1000_0003);
    wr_word(2'd0, 1'b1, 32'h8000_0002);
    look(32'h1000_1234, RD, 1'b0, 1'b1, 32'h8000_1234, 1'b0, "R4 basic read");
    look(32'h1001_FFFF, WR, 1'b1, 1'b1, 32'h8001_FFFF, 1'b0, "R5 pp10 write ok");
    look(32'h1002_0000, RD, 1'b0, 1'b0, 32'h0, 1'b0, "R3 R7 above 128K miss");
  endtask

  task automatic t_length();
    wr_word(2'd1, 1'b0, 32'h2000_000E);
    wr_word(2'd1, 1'b1, 32'h4000_0001);
    look(32'h2006_5678, RD, 1'b0, 1'b1, 32'h4006_5678, 1'b0, "R3 512K hit");
    look(32'h2006_5678, WR, 1'b0, 1'b1, 32'h4006_5678, 1'b1, "R5 pp01 write denied");
    look(32'h2008_0000, RD, 1'b0, 1'b0, 32'h0, 1'b0, "R3 beyond length");
    look(32'h2006_5678, RD, 1'b1, 1'b0, 32'h0, 1'b0, "R2 sup-only in problem");
  endtask

  task automatic t_perm();
    wr_word(2'd2, 1'b0, 32'h3000_0003);
    wr_word(2'd2, 1'b1, 32'h5000_0000);
    look(32'h3000_0010, FE, 1'b0, 1'b1, 32'h5000_0010, 1'b1, "R5 pp00 fetch denied");
    look(32'h3000_0010, RD, 1'b1, 1'b1, 32'h5000_0010, 1'b1, "R5 pp00 read denied");
    wr_word(2'd2, 1'b1, 32'h5000_0003);
    look(32'h3000_0010, FE, 1'b0, 1'b1, 32'h5000_0010, 1'b0, "R5 pp11 fetch ok");
    look(32'h3000_0010, WR, 1'b0, 1'b1, 32'h5000_0010, 1'b1, "R5 pp11 write denied");
  endtask

  task automatic t_priority();
    wr_word(2'd3, 1'b0, 32'h1000_0003);
    wr_word(2'd3, 1'b1, 32'h9000_0002);
    look(32'h1000_1234, RD, 1'b1, 1'b1, 32'h8000_1234, 1'b0, "R6 lowest index wins");
    wr_word(2'd0, 1'b0, 32'h1000_0002);
    look(32'h1000_1234, RD, 1'b1, 1'b1, 32'h9000_1234, 1'b0, "R2 R8 problem uses entry3");
    look(32'h1000_1234, RD, 1'b0, 1'b1, 32'h8000_1234, 1'b0, "R2 R8 sup keeps entry0");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_ea = 32'h2000_0042; req_acc = RD; mode_problem = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_ea = 32'h3000_0000;
    chk(rsp_valid && !req_ready, "R9 stalled not ready", 32'(req_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_real_addr == 32'h4000_0042, "R9 held ra", rsp_real_addr, 32'h4000_0042);
    chk(rsp_valid == 1'b1, "R9 still valid", 32'(rsp_valid), 32'd1);
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 drained", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_length();
    t_perm();
    t_priority();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule